// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers ten interrupt sources for a 68000-style processor: three external request lines, three serial channels, one parallel port and three timers. Each source has a small control register that sets its priority level. A mask register, a pending register and an in-service register use a sparse bit layout: bit 3 is unused. All registers sit on a simple 16-bit register bus with byte enables. The block drives a 3-bit priority level, which is the highest level among sources that are both pending and unmasked.

When the processor acknowledges a level, the block scans the sources in a fixed tie-break order and picks the first one that is pending, unmasked and programmed to that level. It returns an 8-bit vector in the same cycle as the acknowledge. At that clock edge it moves the chosen source from pending to in-service. The vector is made of a 3-bit base register in the top bits and a low part that depends on the source type. For serial sources the low part includes the channel's 2-bit cause code. External edge and level detection is assumed upstream: each source arrives as a one-cycle request pulse.

Top module: `vic_ctrl`

## Requirements
- R1: After reset, the mask register reads 0x07F7 (bits 0-2 and 4-10 set, so every source is masked) and every control register reads 0x0007. Pending, in-service and vector base read 0, and `ipl_o` is 0.
- R2: Register indices on `reg_addr_i` are: 0-9 control of source 0-9, 10 mask, 11 pending, 12 in-service, 13 vector base. Source n (n = 0..2) maps to bit n of the mask, pending and in-service registers. Source n (n = 3..9) maps to bit n+1. A request pulse on `src_req_i[n]` sampled at a clock edge sets the mapped pending bit, which reads back as 1 after that edge.
- R3: `ipl_o` equals the largest control bits [2:0] among sources that are pending and unmasked (mask bit 0). It is 0 if no such source exists.
- R4: A write to the pending or in-service register only clears bits. Afterwards, a bit is still set only where the written data bit is 1 or its byte lane (`reg_be_i[0]` for bits 7:0, `reg_be_i[1]` for bits 15:8) is disabled.
- R5: If a request pulse and a software clear hit the same pending bit in the same cycle, the bit ends up set.
- R6: On acknowledge at level L, sources are scanned in the order 0, 7, 3, 1, 8, 4, 5, 9, 2. The first that is pending, unmasked and at level L wins. Source 6 (parallel port) is never selected.
- R7: At the acknowledge edge, the winner's pending bit is cleared and its in-service bit is set. `ipl_o` then follows the remaining pending sources.
- R8: `vec_o` is valid while `ack_i` is high. With base B = vector-base bits [7:5], the low 5 bits are as follows. Timers 7-9 give src-3. Serial 3-5 give {src-1 in bits 4:2, cause in bits 1:0}. External 0-2 give src.
- R9: If no source wins the acknowledge, `vec_o` is B | 0x1F and no register changes.
- R10: Control writes store data bits [7:0] only when `reg_be_i[0]` is set. Mask writes merge per byte lane, and bit 3 and bits 15:11 always read 0. The vector base keeps data bits [7:5] only, under `reg_be_i[0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register index |
| reg_wdata_i | input | 16 | Write data |
| reg_be_i | input | 2 | Byte lane enables |
| reg_rdata_o | output | 16 | Read data for `reg_addr_i`, combinational |
| src_req_i | input | 10 | One-cycle request pulse per source |
| ser_cause_i | input | 6 | 2-bit cause per serial channel, channel 0 in bits 1:0 |
| ack_i | input | 1 | Interrupt acknowledge strobe |
| ack_level_i | input | 3 | Level being acknowledged |
| vec_o | output | 8 | Vector returned during acknowledge |
| ipl_o | output | 3 | Priority level to the processor |

## Verification
`vec_o` and `reg_rdata_o` are combinational in the current inputs and registered state, so they are due in the same cycle the acknowledge or address is applied. Request pulses, register writes and acknowledge side effects take effect at the next rising edge. `ipl_o` and readback reflect them from that edge on. The bench drives inputs just after a rising edge and advances a behavioural model at the same rising edge. It compares `ipl_o`, `vec_o` and `reg_rdata_o` against the model at every falling edge, and it adds named directed checks with literal expected values.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int NSRC  = 10;
  localparam int NBIT  = NSRC + 1;
  localparam int LVLW  = 3;
  localparam int SRCW  = $clog2(NSRC);
  localparam int NSER  = 3;
  localparam int SER0  = 3;
  localparam int PAR0  = 6;
  localparam int TMR0  = 7;
  localparam int NSCAN = 9;
  localparam int AW    = 4;
  localparam int DW    = 16;

  localparam logic [AW-1:0] RA_MASK  = AW'(10);
  localparam logic [AW-1:0] RA_PEND  = AW'(11);
  localparam logic [AW-1:0] RA_ISR   = AW'(12);
  localparam logic [AW-1:0] RA_VBASE = AW'(13);

  localparam logic [NBIT-1:0] VALID_BITS = NBIT'(11'h7F7);
  localparam logic [7:0]      CTL_RST    = 8'h07;

  function automatic int src_bit(int n);
    return (n < 3) ? n : n + 1;
  endfunction

  // tie-break order among sources sharing a level
  function automatic int scan_at(int k);
    case (k)
      0: return 0;
      1: return 7;
      2: return 3;
      3: return 1;
      4: return 8;
      5: return 4;
      6: return 5;
      7: return 9;
      default: return 2;
    endcase
  endfunction
endpackage

// File: rtl/vic_lvl_max.sv
module vic_lvl_max
  import vic_pkg::*;
(
  input  logic [NSRC-1:0]      act_i,
  input  logic [NSRC*LVLW-1:0] lvl_i,
  output logic [LVLW-1:0]      max_o
);
  always_comb begin
    max_o = '0;
    for (int n = 0; n < NSRC; n++) begin
      if (act_i[n] && lvl_i[n*LVLW +: LVLW] > max_o) max_o = lvl_i[n*LVLW +: LVLW];
    end
  end
endmodule

// File: rtl/vic_ack_pick.sv
module vic_ack_pick
  import vic_pkg::*;
(
  input  logic [NSRC-1:0]      cand_i,
  input  logic [NSRC*LVLW-1:0] lvl_i,
  input  logic [LVLW-1:0]      level_i,
  output logic                 hit_o,
  output logic [SRCW-1:0]      src_o
);
  // walk backwards so the earliest entry in the order wins
  always_comb begin
    hit_o = 1'b0;
    src_o = '0;
    for (int k = NSCAN - 1; k >= 0; k--) begin
      if (cand_i[scan_at(k)] && lvl_i[scan_at(k)*LVLW +: LVLW] == level_i) begin
        hit_o = 1'b1;
        src_o = SRCW'(scan_at(k));
      end
    end
  end
endmodule

// File: rtl/vic_vec_gen.sv
module vic_vec_gen
  import vic_pkg::*;
(
  input  logic              hit_i,
  input  logic [SRCW-1:0]   src_i,
  input  logic [2:0]        base_i,
  input  logic [2*NSER-1:0] cause_i,
  output logic [7:0]        vec_o
);
  logic [4:0] low;
  logic [1:0] cause;

  always_comb begin
    cause = 2'b00;
    for (int c = 0; c < NSER; c++) begin
      if (int'(src_i) == SER0 + c) cause = cause_i[2*c +: 2];
    end
    if (!hit_i)                    low = 5'h1F;
    else if (int'(src_i) >= TMR0)  low = 5'(int'(src_i) - 3);
    else if (int'(src_i) >= SER0)  low = {3'(int'(src_i) - 1), cause};
    else                           low = 5'(src_i);
    vec_o = {base_i, low};
  end
endmodule

// File: rtl/vic_ctrl.sv
module vic_ctrl
  import vic_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [AW-1:0]     reg_addr_i,
  input  logic [DW-1:0]     reg_wdata_i,
  input  logic [1:0]        reg_be_i,
  output logic [DW-1:0]     reg_rdata_o,
  input  logic [NSRC-1:0]   src_req_i,
  input  logic [2*NSER-1:0] ser_cause_i,
  input  logic              ack_i,
  input  logic [LVLW-1:0]   ack_level_i,
  output logic [7:0]        vec_o,
  output logic [LVLW-1:0]   ipl_o
);
  logic [7:0]      ctl_q [NSRC];
  logic [NBIT-1:0] mask_q, pend_q, isr_q;
  logic [NBIT-1:0] pend_d, isr_d, req_bits, win_bits, lane;
  logic [2:0]      vbase_q;
  logic [NSRC-1:0] pend_src, mask_src, cand;
  logic [NSRC*LVLW-1:0] lvl_flat;
  logic            ack_hit;
  logic [SRCW-1:0] win_src;

  assign lane = {{(NBIT-8){reg_be_i[1]}}, {8{reg_be_i[0]}}};

  assign req_bits[3] = 1'b0;
  assign win_bits[3] = 1'b0;
  for (genvar n = 0; n < NSRC; n++) begin : g_map
    assign req_bits[src_bit(n)] = src_req_i[n];
    assign win_bits[src_bit(n)] = ack_i && ack_hit && (win_src == SRCW'(n));
    assign pend_src[n]          = pend_q[src_bit(n)];
    assign mask_src[n]          = mask_q[src_bit(n)];
    assign lvl_flat[n*LVLW +: LVLW] = ctl_q[n][LVLW-1:0];
  end
  assign cand = pend_src & ~mask_src;

  vic_lvl_max u_lvl (.act_i(cand), .lvl_i(lvl_flat), .max_o(ipl_o));

  vic_ack_pick u_pick (
    .cand_i(cand), .lvl_i(lvl_flat), .level_i(ack_level_i),
    .hit_o(ack_hit), .src_o(win_src)
  );

  vic_vec_gen u_vec (
    .hit_i(ack_hit), .src_i(win_src), .base_i(vbase_q),
    .cause_i(ser_cause_i), .vec_o(vec_o)
  );

  // clear by write, clear by ack, then set by request (set wins)
  always_comb begin
    pend_d = pend_q;
    isr_d  = isr_q;
    if (reg_we_i && reg_addr_i == RA_PEND) pend_d &= reg_wdata_i[NBIT-1:0] | ~lane;
    if (reg_we_i && reg_addr_i == RA_ISR)  isr_d  &= reg_wdata_i[NBIT-1:0] | ~lane;
    pend_d = (pend_d & ~win_bits) | req_bits;
    isr_d  = isr_d | win_bits;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int n = 0; n < NSRC; n++) ctl_q[n] <= CTL_RST;
      mask_q  <= VALID_BITS;
      pend_q  <= '0;
      isr_q   <= '0;
      vbase_q <= '0;
    end else begin
      for (int n = 0; n < NSRC; n++)
        if (reg_we_i && reg_be_i[0] && reg_addr_i == AW'(n)) ctl_q[n] <= reg_wdata_i[7:0];
      if (reg_we_i && reg_addr_i == RA_MASK)
        mask_q <= ((mask_q & ~lane) | (reg_wdata_i[NBIT-1:0] & lane)) & VALID_BITS;
      if (reg_we_i && reg_be_i[0] && reg_addr_i == RA_VBASE) vbase_q <= reg_wdata_i[7:5];
      pend_q <= pend_d;
      isr_q  <= isr_d;
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    if (int'(reg_addr_i) < NSRC) reg_rdata_o = DW'(ctl_q[int'(reg_addr_i)]);
    else case (reg_addr_i)
      RA_MASK:  reg_rdata_o = DW'(mask_q);
      RA_PEND:  reg_rdata_o = DW'(pend_q);
      RA_ISR:   reg_rdata_o = DW'(isr_q);
      RA_VBASE: reg_rdata_o = DW'({vbase_q, 5'b0});
      default:  reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/vic_ctrl_chk.sv
module vic_ctrl_chk
  import vic_pkg::*;
(
  input logic            clk_i,
  input logic            rst_ni,
  input logic [NSRC-1:0] src_req_i,
  input logic            ack_i,
  input logic [7:0]      vec_o,
  input logic [LVLW-1:0] ipl_o,
  input logic [NBIT-1:0] pend_q,
  input logic [NBIT-1:0] mask_q,
  input logic [NBIT-1:0] isr_q,
  input logic [NBIT-1:0] win_bits,
  input logic            ack_hit
);
  logic [NBIT-1:0] req_map;
  assign req_map = {src_req_i[9:3], 1'b0, src_req_i[2:0]};

  assert_ipl_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pend_q & ~mask_q) == '0) |-> (ipl_o == '0));

  assert_req_sets_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_map != '0) |=> ((pend_q & $past(req_map)) == $past(req_map)));

  assert_clear_only_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pend_q & ~$past(pend_q)) != '0) |-> ($past(req_map) != '0));

  assert_one_winner_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(win_bits));

  assert_ack_moves_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && ack_hit) |=> ((isr_q & $past(win_bits)) == $past(win_bits)));

  assert_default_vec_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !ack_hit) |-> (vec_o[4:0] == 5'h1F));
endmodule

bind vic_ctrl vic_ctrl_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .src_req_i(src_req_i), .ack_i(ack_i),
  .vec_o(vec_o), .ipl_o(ipl_o), .pend_q(pend_q), .mask_q(mask_q),
  .isr_q(isr_q), .win_bits(win_bits), .ack_hit(ack_hit)
);

// File: tb/vic_ctrl_test.sv
module vic_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [3:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [1:0]  be = '0;
  logic [15:0] rdata;
  logic [9:0]  req = '0;
  logic [5:0]  cause = 6'b10_01_11;
  logic        ack = 1'b0;
  logic [2:0]  ack_lvl = '0;
  logic [7:0]  vec;
  logic [2:0]  ipl;

  int checks = 0, fails = 0, cycles = 0;
  bit done = 0;

  int m_ctl[10];
  int m_mask, m_pend, m_isr, m_base;

  vic_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_be_i(be), .reg_rdata_o(rdata), .src_req_i(req),
    .ser_cause_i(cause), .ack_i(ack), .ack_level_i(ack_lvl), .vec_o(vec), .ipl_o(ipl)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int bpos(int n);
    return (n < 3) ? n : n + 1;
  endfunction

  function automatic int m_ipl();
    int best = 0;
    for (int n = 0; n < 10; n++)
      if (m_pend[bpos(n)] && !m_mask[bpos(n)] && (m_ctl[n] & 7) > best) best = m_ctl[n] & 7;
    return best;
  endfunction

  function automatic int m_win(int lvl);
    int ord[$] = '{0, 7, 3, 1, 8, 4, 5, 9, 2};
    foreach (ord[i])
      if (m_pend[bpos(ord[i])] && !m_mask[bpos(ord[i])] && (m_ctl[ord[i]] & 7) == lvl) return ord[i];
    return -1;
  endfunction

  function automatic int m_vec(int lvl);
    int w = m_win(lvl);
    if (w < 0) return m_base | 'h1F;
    if (w >= 7) return m_base | (w - 3);
    if (w >= 3) return m_base | ((w - 1) << 2) | ((int'(cause) >> (2 * (w - 3))) & 3);
    return m_base | w;
  endfunction

  function automatic int m_rd(int a);
    if (a < 10) return m_ctl[a];
    case (a)
      10: return m_mask;
      11: return m_pend;
      12: return m_isr;
      13: return m_base;
      default: return 0;
    endcase
  endfunction

  task automatic m_reset();
    for (int n = 0; n < 10; n++) m_ctl[n] = 7;
    m_mask = 'h7F7; m_pend = 0; m_isr = 0; m_base = 0;
  endtask

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // reference model step
  always @(posedge clk) if (rst_n) begin
    int bm, w, np, ni;
    bm = (be[1] ? 'hFF00 : 0) | (be[0] ? 'h00FF : 0);
    w  = ack ? m_win(int'(ack_lvl)) : -1;
    np = m_pend; ni = m_isr;
    if (we) begin
      if (int'(addr) < 10 && be[0]) m_ctl[addr] = int'(wdata) & 'hFF;
      if (addr == 10) m_mask = ((m_mask & ~bm) | (int'(wdata) & bm)) & 'h7F7;
      if (addr == 11) np = np & (int'(wdata) | ~bm);
      if (addr == 12) ni = ni & (int'(wdata) | ~bm);
      if (addr == 13 && be[0]) m_base = int'(wdata) & 'hE0;
    end
    if (w >= 0) begin
      np = np & ~(1 << bpos(w));
      ni = ni | (1 << bpos(w));
    end
    for (int n = 0; n < 10; n++) if (req[n]) np = np | (1 << bpos(n));
    m_pend = np & 'h7F7; m_isr = ni & 'h7F7;
  end

  // cycle compare against the model
  always @(negedge clk) if (rst_n && !done) begin
    chk("R3 ipl", int'(ipl), m_ipl());
    chk("R10 readback", int'(rdata), m_rd(int'(addr)));
    if (ack) chk("R8 vector", int'(vec), m_vec(int'(ack_lvl)));
  end

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected<20000", cycles);
      summary();
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr(int a, int d, int b);
    we = 1; addr = 4'(a); wdata = 16'(d); be = 2'(b);
    tick();
    we = 0; be = 0;
  endtask

  task automatic rd_chk(string tag, int a, int exp);
    addr = 4'(a); #2;
    chk(tag, int'(rdata), exp);
  endtask

  task automatic pulse(int mask);
    req = 10'(mask);
    tick();
    req = '0;
  endtask

  task automatic ack_chk(string tag, int lvl, int exp);
    ack = 1; ack_lvl = 3'(lvl); #2;
    chk(tag, int'(vec), exp);
    tick();
    ack = 0;
  endtask

  initial begin
    m_reset();
    #(3 * CLK_PERIOD) rst_n = 1;
    #2; tick();
    // R1 reset state
    rd_chk("R1 mask", 10, 'h7F7);
    rd_chk("R1 ctl0", 0, 'h07);
    rd_chk("R1 ctl9", 9, 'h07);
    rd_chk("R1 pend", 11, 0);
    rd_chk("R1 isr", 12, 0);
    chk("R1 ipl", int'(ipl), 0);
    // R2 mapping: sources 6 and 9 to bits 7 and 10
    pulse('h240);
    rd_chk("R2 pend map", 11, 'h480);
    chk("R3 masked ipl", int'(ipl), 0);
    // levels
    wr(0, 'h25, 1); wr(1, 5, 1); wr(2, 2, 1); wr(3, 5, 1); wr(4, 3, 1);
    wr(5, 1, 1); wr(6, 6, 1); wr(7, 5, 1); wr(8, 4, 1); wr(9, 6, 1);
    wr(0, 'h00FF, 2);
    rd_chk("R10 ctl lane", 0, 'h25);
    wr(10, 'hFFFF, 2);
    rd_chk("R10 mask lane", 10, 'h7F7);
    wr(10, 0, 3);
    rd_chk("R10 mask clr", 10, 0);
    chk("R3 ipl six", int'(ipl), 6);
    wr(13, 'h00A5, 1);
    rd_chk("R10 base", 13, 'hA0);
    // R6 source 6 is skipped; 9 wins level 6
    ack_chk("R6 R8 timer9", 6, 'hA6);
    rd_chk("R7 pend", 11, 'h080);
    rd_chk("R7 isr", 12, 'h400);
    chk("R7 ipl", int'(ipl), 6);
    ack_chk("R6 R9 parallel skipped", 6, 'hBF);
    rd_chk("R9 pend kept", 11, 'h080);
    wr(11, 'hFF7F, 3);
    rd_chk("R4 pend clear", 11, 0);
    chk("R3 ipl none", int'(ipl), 0);
    // tie-break at level 5
    pulse('h08B);
    rd_chk("R2 pend four", 11, 'h113);
    chk("R3 ipl five", int'(ipl), 5);
    ack_chk("R6 first ext0", 5, 'hA0);
    ack_chk("R6 then timer7", 5, 'hA4);
    ack_chk("R6 R8 serial3", 5, 'hAB);
    ack_chk("R6 then ext1", 5, 'hA1);
    rd_chk("R7 isr after", 12, 'h513);
    chk("R7 ipl drop", int'(ipl), 0);
    pulse('h130);
    pulse('h004);
    ack_chk("R8 serial4", 3, 'hAD);
    ack_chk("R8 serial5", 1, 'hB2);
    ack_chk("R8 timer8", 4, 'hA5);
    ack_chk("R8 ext2", 2, 'hA2);
    rd_chk("R7 isr all", 12, 'h777);
    wr(12, 0, 1);
    rd_chk("R4 isr lane", 12, 'h700);
    // R5 set beats clear
    req = 10'h004; wr(11, 0, 3); req = '0;
    rd_chk("R5 set wins", 11, 'h004);
    wr(10, 'h0004, 3);
    chk("R3 masked", int'(ipl), 0);
    ack_chk("R9 masked default", 2, 'hBF);
    rd_chk("R9 pend unchanged", 11, 'h004);
    tick(); tick();
    summary();
  end
endmodule